// File: doc/BRIEF.md
# Three-Port Programmable Parallel Interface

This block is a register-mapped parallel I/O controller with three 8-bit ports, called A, B and C. A host reaches it through four local register offsets. Offsets 0, 1 and 2 are the data registers of ports A, B and C. Offset 3 is the control register. A control word sets the direction of each port. Port C is split into an upper nibble and a lower nibble, and each nibble has its own direction. For every line the block drives an output-enable, so that external bidirectional buffers turn round as soon as a new control word takes effect.

Port A also has a latched handshake mode. In this mode a rising edge on a latch strobe captures the port A pins into a holding register. A host read of port A returns that held byte and raises an acknowledge. The acknowledge drops when the strobe falls, and both signals rest low. The host interface consists of plain single-cycle strobes. It has no back-pressure: every write or read strobe is accepted in the cycle it is presented, and read data is always ready one cycle later. The block has no streaming interface, so it uses no valid/ready pair.

Top module: `tri_port_pio`

## Requirements
- R1: After reset every port is an input, all output-enables and output latches are 0, the acknowledge is low and the read data is 0.
- R2: A control write with bit 7 = 1 is a mode word. Bit 4 = 1 makes port A an input, bit 1 port B, bit 3 upper C and bit 0 lower C. Each line's output-enable is the inverse of its input flag, and it is valid from the clock edge that takes the write.
- R3: A control write with bit 7 = 0 changes neither the control register nor any output-enable.
- R4: A mode word clears all three output latches, the port A holding register and the acknowledge to 0.
- R5: A write to offset 0, 1 or 2 loads that port's output latch, and the port's output pins follow the latch.
- R6: A read of an input port returns the pin values sampled at the read strobe's clock edge. The value appears on the read data one cycle after the strobe and holds until the next read.
- R7: A read of an output port returns its output latch. For port C this applies per nibble, so a mixed-direction read combines latch and pin nibbles.
- R8: A read of offset 3 returns the last mode word, which is 0x9B after reset.
- R9: Handshake mode is control bit 5 = 1 together with port A as input. In this mode a rising strobe edge captures the port A pins into the holding register, and port A reads return the held byte instead of the live pins.
- R10: In handshake mode the acknowledge rises the cycle after a port A read and falls the cycle after the strobe is sampled low following a high. A falling strobe wins over a simultaneous read.
- R11: Outside handshake mode the strobe is ignored, the acknowledge stays low and port A reads return the live pins or the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | 2 | Register offset (0 A, 1 B, 2 C, 3 control) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-line output-enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-line output-enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-line output-enable |
| hs_strobe | input | 1 | Port A handshake latch strobe |
| hs_ack | output | 1 | Port A handshake acknowledge |

## Verification
All results are due one clock after the stimulus that causes them. Output-enables, latches and the control value follow a write one edge later. Read data follows a read strobe one edge later, and the acknowledge moves one edge after a port A read or a sampled strobe fall. The bench drives every input at the falling edge, updates a behavioural model at the rising edge with those same inputs, and compares all outputs at the next falling edge. It also runs directed checks, which sample only after the edge that completes each operation.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam logic [1:0] OFS_A   = 2'd0;
  localparam logic [1:0] OFS_B   = 2'd1;
  localparam logic [1:0] OFS_C   = 2'd2;
  localparam logic [1:0] OFS_CTL = 2'd3;

  localparam logic [7:0] CTL_RESET = 8'h9B;

  localparam int BIT_MODE  = 7;
  localparam int BIT_HS    = 5;
  localparam int BIT_A_IN  = 4;
  localparam int BIT_CU_IN = 3;
  localparam int BIT_B_IN  = 1;
  localparam int BIT_CL_IN = 0;

  typedef struct packed {
    logic hs_en;
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_t;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_word,
  output dir_t          dir,
  output logic          mode_set
);
  logic ctl_sel;

  assign ctl_sel  = wr_en && (addr == OFS_CTL);
  assign mode_set = ctl_sel && wdata[BIT_MODE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_word <= DW'(CTL_RESET);
    else if (mode_set) ctl_word <= wdata;
  end

  always_comb begin
    dir.hs_en = ctl_word[BIT_HS];
    dir.a_in  = ctl_word[BIT_A_IN];
    dir.b_in  = ctl_word[BIT_B_IN];
    dir.cu_in = ctl_word[BIT_CU_IN];
    dir.cl_in = ctl_word[BIT_CL_IN];
  end

  AST_PLAIN_WORD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_sel && !wdata[BIT_MODE]) |=> $stable(ctl_word)); // R3
endmodule

// File: rtl/pio_latch.sv
module pio_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (we)  q <= d;
  end

  AST_CLEAR_ON_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0)); // R4
  AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (q == $past(d))); // R5
endmodule

// File: rtl/pio_hs.sv
module pio_hs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         strobe,
  input  logic [W-1:0] pins,
  input  logic         rd_a,
  output logic [W-1:0] hold,
  output logic         ack
);
  logic strobe_q;
  logic rise;
  logic fall;

  assign rise = strobe && !strobe_q;
  assign fall = !strobe && strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold <= '0;
    else if (clr)        hold <= '0;
    else if (en && rise) hold <= pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ack <= 1'b0;
    else if (clr)  ack <= 1'b0;
    else if (!en)  ack <= 1'b0;
    else if (fall) ack <= 1'b0;
    else if (rd_a) ack <= 1'b1;
  end

  AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && strobe && !strobe_q) |=> (hold == $past(pins))); // R9
  AST_ACK_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && rd_a && !(strobe_q && !strobe)) |=> ack); // R10
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && !strobe) |=> !ack); // R10
  AST_ACK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> !ack); // R11
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe,
  input  logic          hs_strobe,
  output logic          hs_ack
);
  localparam int NPORT = 3;
  localparam int HW    = DW / 2;

  logic [DW-1:0]            ctl_word;
  dir_t                     dir;
  logic                     mode_set;
  logic [NPORT-1:0][DW-1:0] lat;
  logic [DW-1:0]            hold;
  logic                     hs_active;
  logic                     rd_a;
  logic [DW-1:0]            a_val, b_val, c_val;

  pio_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctl_word(ctl_word), .dir(dir), .mode_set(mode_set)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pio_latch #(.W(DW)) u_lat (
      .clk(clk), .rst_n(rst_n), .clr(mode_set),
      .we(wr_en && (addr == 2'(p))), .d(wdata), .q(lat[p])
    );
  end

  assign hs_active = dir.hs_en && dir.a_in;
  assign rd_a      = rd_en && (addr == OFS_A);

  pio_hs #(.W(DW)) u_hs (
    .clk(clk), .rst_n(rst_n), .en(hs_active), .clr(mode_set),
    .strobe(hs_strobe), .pins(pa_in), .rd_a(rd_a), .hold(hold), .ack(hs_ack)
  );

  assign pa_out = lat[0];
  assign pb_out = lat[1];
  assign pc_out = lat[2];
  assign pa_oe  = {DW{~dir.a_in}};
  assign pb_oe  = {DW{~dir.b_in}};
  assign pc_oe  = {{HW{~dir.cu_in}}, {HW{~dir.cl_in}}};

  always_comb begin
    if (hs_active)      a_val = hold;
    else if (dir.a_in)  a_val = pa_in;
    else                a_val = lat[0];
    b_val = dir.b_in ? pb_in : lat[1];
    c_val[DW-1:HW] = dir.cu_in ? pc_in[DW-1:HW] : lat[2][DW-1:HW];
    c_val[HW-1:0]  = dir.cl_in ? pc_in[HW-1:0]  : lat[2][HW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        OFS_A:   rdata <= a_val;
        OFS_B:   rdata <= b_val;
        OFS_C:   rdata <= c_val;
        default: rdata <= ctl_word;
      endcase
    end
  end

  AST_OE_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |=> (pa_oe == {DW{~$past(wdata[BIT_A_IN])}})); // R2
  AST_LIVE_PIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_B && dir.b_in) |=> (rdata == $past(pb_in))); // R6
  AST_OUT_PORT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_B && !dir.b_in) |=> (rdata == $past(pb_out))); // R7
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> $stable(rdata)); // R6
endmodule

// File: tb/tri_port_pio_test.sv
module tri_port_pio_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic       hs_strobe = 1'b0;
  logic       hs_ack;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tri_port_pio uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .hs_strobe(hs_strobe), .hs_ack(hs_ack)
  );

  // behavioural reference model
  logic [7:0] m_ctl, m_la, m_lb, m_lc, m_hold, m_rd;
  logic       m_ack, m_sq;

  always @(posedge clk) begin : model
    logic hs, rise, fall, rda, ms;
    logic [7:0] av, bv, cv;
    if (!rst_n) begin
      m_ctl = 8'h9B; m_la = 0; m_lb = 0; m_lc = 0; m_hold = 0;
      m_rd = 0; m_ack = 0; m_sq = 0;
    end else begin
      hs   = m_ctl[5] && m_ctl[4];
      rise = hs_strobe && !m_sq;
      fall = !hs_strobe && m_sq;
      rda  = rd_en && addr == 2'd0;
      ms   = wr_en && addr == 2'd3 && wdata[7];
      av = hs ? m_hold : (m_ctl[4] ? pa_in : m_la);
      bv = m_ctl[1] ? pb_in : m_lb;
      cv = {m_ctl[3] ? pc_in[7:4] : m_lc[7:4], m_ctl[0] ? pc_in[3:0] : m_lc[3:0]};
      if (rd_en) begin
        case (addr)
          2'd0: m_rd = av;
          2'd1: m_rd = bv;
          2'd2: m_rd = cv;
          default: m_rd = m_ctl;
        endcase
      end
      if (ms) m_ack = 0;
      else if (!hs) m_ack = 0;
      else if (fall) m_ack = 0;
      else if (rda) m_ack = 1;
      if (ms) m_hold = 0;
      else if (hs && rise) m_hold = pa_in;
      m_sq = hs_strobe;
      if (ms) begin m_ctl = wdata; m_la = 0; m_lb = 0; m_lc = 0; end
      else if (wr_en) begin
        case (addr)
          2'd0: m_la = wdata;
          2'd1: m_lb = wdata;
          2'd2: m_lc = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // compare against the model every cycle
  always @(negedge clk) begin
    if (!done) begin
      chk("R2", "pa_oe", pa_oe, {8{~m_ctl[4]}});
      chk("R2", "pb_oe", pb_oe, {8{~m_ctl[1]}});
      chk("R2", "pc_oe", pc_oe, {{4{~m_ctl[3]}}, {4{~m_ctl[0]}}});
      chk("R5", "pa_out", pa_out, m_la);
      chk("R5", "pb_out", pb_out, m_lb);
      chk("R5", "pc_out", pc_out, m_lc);
      chk("R6", "rdata", rdata, m_rd);
      chk("R10", "hs_ack", hs_ack, m_ack);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "pa_oe", pa_oe, 0);
    chk("R1", "pc_oe", pc_oe, 0);
    chk("R1", "hs_ack", hs_ack, 0);
    chk("R1", "rdata", rdata, 0);
    rd(2'd3);
    chk("R8", "reset ctl", rdata, 8'h9B);

    // R5 latch loads even while input; R6 live pin read
    wr(2'd0, 8'h5A);
    chk("R5", "pa_out", pa_out, 8'h5A);
    pa_in = 8'h3C;
    rd(2'd0);
    chk("R6", "live A", rdata, 8'h3C);
    pa_in = 8'h99;
    @(negedge clk);
    chk("R6", "rdata holds", rdata, 8'h3C);

    // R2 / R4 all outputs
    wr(2'd3, 8'h80);
    chk("R2", "pa_oe out", pa_oe, 8'hFF);
    chk("R2", "pc_oe out", pc_oe, 8'hFF);
    chk("R4", "latch cleared", pa_out, 0);
    rd(2'd3);
    chk("R8", "ctl 80", rdata, 8'h80);

    // R7 output read-back
    wr(2'd0, 8'h11); wr(2'd1, 8'h22); wr(2'd2, 8'h33);
    pb_in = 8'hEE;
    rd(2'd0); chk("R7", "A latch", rdata, 8'h11);
    rd(2'd1); chk("R7", "B latch", rdata, 8'h22);
    rd(2'd2); chk("R7", "C latch", rdata, 8'h33);

    // A,B out, C in
    wr(2'd3, 8'h89);
    chk("R4", "B cleared", pb_out, 0);
    chk("R2", "pc_oe in", pc_oe, 8'h00);
    pc_in = 8'hC5;
    rd(2'd2); chk("R6", "C pins", rdata, 8'hC5);

    // split C: upper out, lower in
    wr(2'd3, 8'h81);
    chk("R2", "pc_oe split", pc_oe, 8'hF0);
    wr(2'd2, 8'hA7);
    pc_in = 8'h5E;
    rd(2'd2); chk("R7", "C mixed", rdata, 8'hAE);

    // R3 plain word ignored
    wr(2'd3, 8'h1B);
    chk("R3", "pa_oe kept", pa_oe, 8'hFF);
    chk("R3", "pc_oe kept", pc_oe, 8'hF0);
    rd(2'd3); chk("R3", "ctl kept", rdata, 8'h81);

    // R9 / R10 handshake: A input, B and C outputs
    wr(2'd3, 8'hB0);
    chk("R10", "ack rest", hs_ack, 0);
    pa_in = 8'h77;
    @(negedge clk); hs_strobe = 1;
    @(negedge clk); pa_in = 8'h12;
    @(negedge clk);
    rd(2'd0);
    chk("R9", "held byte", rdata, 8'h77);
    chk("R10", "ack high", hs_ack, 1);
    @(negedge clk);
    chk("R10", "ack stays", hs_ack, 1);
    hs_strobe = 0;
    @(negedge clk);
    chk("R10", "ack falls", hs_ack, 0);
    // falling strobe wins over a read in the same cycle
    @(negedge clk); hs_strobe = 1;
    @(negedge clk); hs_strobe = 0; rd_en = 1; addr = 2'd0;
    @(negedge clk); rd_en = 0;
    chk("R10", "fall wins", hs_ack, 0);
    chk("R9", "recaptured", rdata, 8'h12);

    // R11 direct mode ignores strobe
    wr(2'd3, 8'h9B);
    pa_in = 8'h4D;
    @(negedge clk); hs_strobe = 1;
    @(negedge clk); pa_in = 8'h6B;
    rd(2'd0);
    chk("R11", "live A", rdata, 8'h6B);
    chk("R11", "ack low", hs_ack, 0);
    hs_strobe = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule